// File: doc/BRIEF.md
# Double-Precision to Signed 64-bit Integer Converter

This block takes a 64-bit double-precision floating-point operand and a 2-bit rounding selector and returns a signed 64-bit two's-complement integer. It also returns three flags: invalid, integer overflow and inexact. The datapath has four steps. It first classifies and unpacks the operand. It then lines the significand up with the integer binary point. Next it rounds the unsigned magnitude. The sign is applied last, by two's-complement negation.

Operands are presented with a one-cycle `in_valid` strobe. Result and flags are registered and appear with `out_valid` on the following clock edge. They hold their values until the next accepted operand. Special operands and out-of-range values do not saturate in the usual way. Infinities and NaNs return the largest positive integer. An oversized finite value returns the wrapped low 64 bits of its magnitude, with flags raised.

Top module: `dbl_to_int_conv`

## Requirements
- R1: An operand with exponent field all ones and fraction bit 51 clear returns 0x7FFF_FFFF_FFFF_FFFF with the invalid flag set and the other two flags clear. This covers infinity (zero fraction) and the signalling NaN (nonzero fraction).
- R2: An operand with exponent field all ones and fraction bit 51 set (quiet NaN) returns 0x7FFF_FFFF_FFFF_FFFF with all three flags clear.
- R3: Bits 63, 62..52 and 51..0 hold sign, biased exponent and fraction. A normal operand has the magnitude (1.fraction)·2^(exp−1023). An exponent field of zero gives fraction·2^−1074 with no hidden one. A signed zero returns 0 with no flag.
- R4: Rounding selector 00 rounds to nearest, ties to even. The truncated magnitude is incremented when the first discarded bit is 1 and either a lower discarded bit is 1 or the retained lsb is 1.
- R5: Rounding selector 01 (chop) returns the truncated magnitude unchanged.
- R6: Rounding selector 11 increments the truncated magnitude, and selector 10 decrements it modulo 2^64, whenever any discarded bit is nonzero. Both act on the magnitude whatever the operand sign.
- R7: The inexact flag is set exactly when a discarded fraction bit is nonzero, or when R8 applies.
- R8: A finite operand whose unbiased exponent is 63 or more (magnitude ≥ 2^63) sets both the integer-overflow and inexact flags. It returns the low 64 bits of the magnitude, negated when the sign is 1.
- R9: When the sign bit is 1, the output is the two's complement (mod 2^64) of the rounded magnitude.
- R10: Bits shifted out during right alignment are collected into a sticky bit at any shift distance, including the smallest denormal. This keeps R4, R6 and R7 correct for tiny values.
- R11: After reset, out_valid, result and all flags are 0. An operand accepted with in_valid appears one clock later with out_valid = 1. Without in_valid the outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 64 | Double-precision operand |
| rnd_mode | input | 2 | Rounding selector: 00 nearest, 01 chop, 10 down, 11 up |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Signed integer result |
| flag_invalid | output | 1 | Invalid operation flag |
| flag_int_ovf | output | 1 | Integer overflow flag |
| flag_inexact | output | 1 | Inexact flag |

## Verification
The bench goes after ties at the nearest setting. A design that rounds half away from zero would return 3 for 2.5 instead of 2. It also covers the directed modes on negative values and on positive values. A design that applied the sign before rounding would return −2 instead of −3 for −2.5 rounded up. It would also fail to return 1 for 2.5 rounded down.

Exponents around 62, 63 and 64 expose overflow detection that is off by one, or a design that saturates instead of wrapping. The smallest denormal under round-up catches a sticky bit that is dropped once the shift distance exceeds the alignment window. Quiet and signalling NaNs, and infinities of both signs, separate the invalid flag from the silent NaN case.

// File: rtl/f2i_pkg.sv
// Shared types for the double-to-integer converter.
// Assumes a two-bit rounding selector and a six-way operand classification.
package f2i_pkg;

    // Rounding selector encoding seen on the top-level port.
    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_CHOP = 2'b01,
        RND_DOWN = 2'b10,
        RND_UP   = 2'b11
    } rnd_mode_e;

    // Operand classes produced by the unpack stage.
    typedef enum logic [2:0] {
        OPC_ZERO = 3'd0,
        OPC_SUBN = 3'd1,
        OPC_NORM = 3'd2,
        OPC_INF  = 3'd3,
        OPC_QNAN = 3'd4,
        OPC_SNAN = 3'd5
    } op_class_e;

endpackage

// File: rtl/f2i_unpack.sv
// Splits a floating-point operand into sign, class, unbiased exponent and
// significand. A normal operand gets its hidden one made explicit. A
// subnormal (or zero) operand takes the fixed minimum exponent 1-BIAS and
// gets no hidden one. Purely combinational.
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int XW    = EXP_W + 2,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [OP_W-1:0]      operand,
    output logic                 sign,
    output op_class_e            cls,
    output logic signed [XW-1:0] unb_exp,
    output logic [SIG_W-1:0]     sig
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // Field extraction and class decode.
    always_comb begin
        sign    = operand[OP_W-1];
        exp_f   = operand[FRAC_W +: EXP_W];
        frac_f  = operand[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
        if (exp_max) begin
            if (!frac_nz)              cls = OPC_INF;
            else if (frac_f[FRAC_W-1]) cls = OPC_QNAN;
            else                       cls = OPC_SNAN;
        end else if (exp_min) begin
            cls = frac_nz ? OPC_SUBN : OPC_ZERO;
        end else begin
            cls = OPC_NORM;
        end
    end

    // Exponent unbiasing and significand assembly.
    always_comb begin
        if (exp_min) begin
            unb_exp = $signed(XW'(1) - XW'(BIAS));
            sig     = {1'b0, frac_f};
        end else begin
            unb_exp = $signed({2'b00, exp_f} - XW'(BIAS));
            sig     = {1'b1, frac_f};
        end
    end

endmodule

// File: rtl/f2i_align.sv
// Moves the significand so that its integer part sits in the low bits of an
// INT_W-bit magnitude.
// Left path (exponent >= FRAC_W): shifts left, keeps the low INT_W bits and
// flags overflow once the exponent reaches INT_W-1.
// Right path: shifts into a window that holds the integer part, a guard bit
// and FRAC_W+1 lower bits. Any bit that drops off the window is ORed into
// the sticky bit, so that arbitrarily long shifts stay exact for rounding.
// Purely combinational.
module f2i_align #(
    parameter int FRAC_W = 52,
    parameter int XW     = 13,
    parameter int INT_W  = 64,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic signed [XW-1:0] unb_exp,
    input  logic [SIG_W-1:0]     sig,
    output logic [INT_W-1:0]     mag,
    output logic                 guard,
    output logic                 sticky,
    output logic                 ovf
);
    localparam int GRD_W = FRAC_W + 2;
    localparam int VEC_W = SIG_W + GRD_W;
    localparam int SHW   = $clog2(VEC_W + 1);

    logic             is_left;
    logic [XW-1:0]    ls_amt;
    logic [XW-1:0]    rs_full;
    logic [SHW-1:0]   rs_amt;
    logic [INT_W-1:0] mag_l;
    logic             ovf_l;
    logic [VEC_W-1:0] window;
    logic [VEC_W-1:0] shifted;
    logic [VEC_W-1:0] dropped;
    logic [INT_W-1:0] mag_r;
    logic             guard_r;
    logic             sticky_r;

    // Shift direction and distances.
    always_comb begin
        is_left = (unb_exp >= $signed(XW'(FRAC_W)));
        ls_amt  = XW'(unb_exp - $signed(XW'(FRAC_W)));
        rs_full = XW'($signed(XW'(FRAC_W)) - unb_exp);
        rs_amt  = (rs_full >= XW'(VEC_W)) ? SHW'(VEC_W) : rs_full[SHW-1:0];
    end

    // Left path: integer with no fraction, wrapped to INT_W bits.
    always_comb begin
        mag_l = (ls_amt < XW'(INT_W)) ? (INT_W'(sig) << ls_amt) : '0;
        ovf_l = (unb_exp >= $signed(XW'(INT_W - 1)));
    end

    // Right path: integer part, guard bit and sticky collection.
    always_comb begin
        window   = {sig, {GRD_W{1'b0}}};
        shifted  = window >> rs_amt;
        dropped  = window & ~({VEC_W{1'b1}} << rs_amt);
        mag_r    = INT_W'(shifted[VEC_W-1:GRD_W]);
        guard_r  = shifted[GRD_W-1];
        sticky_r = (|shifted[GRD_W-2:0]) | (|dropped);
    end

    // Path selection.
    always_comb begin
        if (is_left) begin
            mag    = mag_l;
            guard  = 1'b0;
            sticky = 1'b0;
            ovf    = ovf_l;
        end else begin
            mag    = mag_r;
            guard  = guard_r;
            sticky = sticky_r;
            ovf    = 1'b0;
        end
    end

endmodule

// File: rtl/f2i_round.sv
// Rounds the unsigned magnitude using the guard and sticky bits, then
// applies the sign by two's-complement negation. Directed modes act on the
// magnitude: "up" adds one and "down" subtracts one when anything was
// discarded, whatever the sign. Purely combinational.
module f2i_round
    import f2i_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic [1:0]       rmode,
    input  logic             sign,
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  logic             ovf,
    output logic [INT_W-1:0] value,
    output logic             inexact
);
    logic             lost_any;
    logic             inc;
    logic             dec;
    logic [INT_W-1:0] mag_adj;

    // Increment / decrement decision per rounding mode.
    always_comb begin
        lost_any = guard | sticky;
        inc      = 1'b0;
        dec      = 1'b0;
        case (rnd_mode_e'(rmode))
            RND_NEAR: inc = guard & (sticky | mag[0]);
            RND_CHOP: ;
            RND_DOWN: dec = lost_any;
            RND_UP:   inc = lost_any;
            default:  ;
        endcase
    end

    // Magnitude adjustment, sign application and inexact flag.
    always_comb begin
        mag_adj = mag + INT_W'(inc) - INT_W'(dec);
        value   = sign ? (~mag_adj + INT_W'(1)) : mag_adj;
        inexact = lost_any | ovf;
    end

endmodule

// File: rtl/dbl_to_int_conv.sv
// Top of the double-to-signed-integer converter. Takes one operand per
// in_valid strobe and registers the result and flags one cycle later.
// Infinities and NaNs return the largest positive integer. Finite values go
// through unpack, align and round.
// Assumes a synchronous active-low reset and a one-cycle strobe.
module dbl_to_int_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    localparam int OP_W  = 1 + EXP_W + FRAC_W,
    localparam int XW    = EXP_W + 2,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  operand,
    input  logic [1:0]       rnd_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_int_ovf,
    output logic             flag_inexact
);
    localparam logic [INT_W-1:0] SAT_VAL = {1'b0, {(INT_W-1){1'b1}}};

    logic                 sign;
    op_class_e            cls;
    logic signed [XW-1:0] unb_exp;
    logic [SIG_W-1:0]     sig;
    logic [INT_W-1:0]     mag;
    logic                 guard;
    logic                 sticky;
    logic                 ovf;
    logic [INT_W-1:0]     rounded;
    logic                 inexact;
    logic [INT_W-1:0]     nxt_result;
    logic                 nxt_inv;
    logic                 nxt_ovf;
    logic                 nxt_inx;

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .operand (operand),
        .sign    (sign),
        .cls     (cls),
        .unb_exp (unb_exp),
        .sig     (sig)
    );

    f2i_align #(.FRAC_W(FRAC_W), .XW(XW), .INT_W(INT_W)) u_align (
        .unb_exp (unb_exp),
        .sig     (sig),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .ovf     (ovf)
    );

    f2i_round #(.INT_W(INT_W)) u_round (
        .rmode   (rnd_mode),
        .sign    (sign),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .ovf     (ovf),
        .value   (rounded),
        .inexact (inexact)
    );

    // Special-operand override of the arithmetic result.
    always_comb begin
        case (cls)
            OPC_INF, OPC_SNAN: begin
                nxt_result = SAT_VAL;
                nxt_inv    = 1'b1;
                nxt_ovf    = 1'b0;
                nxt_inx    = 1'b0;
            end
            OPC_QNAN: begin
                nxt_result = SAT_VAL;
                nxt_inv    = 1'b0;
                nxt_ovf    = 1'b0;
                nxt_inx    = 1'b0;
            end
            default: begin
                nxt_result = rounded;
                nxt_inv    = 1'b0;
                nxt_ovf    = ovf;
                nxt_inx    = inexact;
            end
        endcase
    end

    // Output register: captures on in_valid, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_int_ovf <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= nxt_result;
                flag_invalid <= nxt_inv;
                flag_int_ovf <= nxt_ovf;
                flag_inexact <= nxt_inx;
            end
        end
    end

    // R1: an invalid result is always the saturation pattern with no other flag.
    assert_sat_on_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result == SAT_VAL) && !flag_int_ovf && !flag_inexact);

    // R3: a normal operand always carries an explicit leading one.
    assert_hidden_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == OPC_NORM) |-> sig[FRAC_W]);

    // R8: integer overflow never comes without inexact.
    assert_ovf_implies_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_int_ovf |-> flag_inexact);

    // R8: the left-shift path never hands discarded bits to rounding.
    assert_ovf_no_fraction_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !guard && !sticky);

    // R11: one-cycle latency of the valid strobe.
    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: outputs hold while no operand is accepted.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_inexact));

endmodule

// File: tb/dbl_to_int_conv_test.sv
module dbl_to_int_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid;
    logic        flag_int_ovf;
    logic        flag_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dbl_to_int_conv uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .operand      (operand),
        .rnd_mode     (rnd_mode),
        .out_valid    (out_valid),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_int_ovf (flag_int_ovf),
        .flag_inexact (flag_inexact)
    );

    always #4 clk = ~clk;

    // Reference model written from the requirements: {result, inv, ovf, inx}.
    function automatic logic [66:0] ref_conv(input logic [63:0] op, input logic [1:0] rm);
        logic        sg;
        logic [10:0] ex;
        logic [51:0] fr;
        logic [63:0] m;
        logic        g;
        logic        s;
        logic        ov;
        int          e;
        sg = op[63]; ex = op[62:52]; fr = op[51:0];
        g = 1'b0; s = 1'b0; ov = 1'b0;
        if (ex == 11'h7FF) begin
            if (fr[51]) return {64'h7FFF_FFFF_FFFF_FFFF, 3'b000};   // R2
            return {64'h7FFF_FFFF_FFFF_FFFF, 3'b100};               // R1
        end
        if (ex == 0) begin e = -1022; m = {12'd0, fr}; end
        else begin e = int'(ex) - 1023; m = {11'd0, 1'b1, fr}; end
        if (e >= 52) begin
            for (int k = 0; k < e - 52; k++) begin
                if (m[63]) ov = 1'b1;
                m = m << 1;
            end
            if (m[63]) ov = 1'b1;
            if (e >= 63) ov = 1'b1;
        end else begin
            for (int k = 0; k < 52 - e; k++) begin
                s = s | g;
                g = m[0];
                m = m >> 1;
            end
        end
        case (rm)
            2'b00: if (g && (s || m[0])) m = m + 64'd1;
            2'b11: if (g || s) m = m + 64'd1;
            2'b10: if (g || s) m = m - 64'd1;
            default: ;
        endcase
        if (sg) m = -m;
        return {m, 1'b0, ov, (g | s | ov)};
    endfunction

    // Apply one operand, wait for the registered result, compare.
    task automatic run_vec(input logic [63:0] op, input logic [1:0] rm, input string tag);
        logic [66:0] exp_v;
        logic [66:0] got_v;
        exp_v = ref_conv(op, rm);
        @(negedge clk);
        operand  = op;
        rnd_mode = rm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got_v = {result, flag_invalid, flag_int_ovf, flag_inexact};
        checks++;
        if (!out_valid || got_v !== exp_v) begin
            errors++;
            $display("FAIL %s op=%h rm=%0d actual=%h/%b%b%b v=%b expected=%h/%b%b%b",
                     tag, op, rm, got_v[66:3], got_v[2], got_v[1], got_v[0], out_valid,
                     exp_v[66:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11 reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || flag_invalid || flag_int_ovf || flag_inexact) begin
            errors++;
            $display("FAIL R11 reset actual=%b/%h expected=0/0", out_valid, result);
        end
        rst_n = 1'b1;

        run_vec(64'h7FF0_0000_0000_0000, 2'b00, "R1 +inf");
        run_vec(64'hFFF0_0000_0000_0000, 2'b11, "R1 -inf");
        run_vec(64'h7FF0_0000_0000_0001, 2'b00, "R1 snan");
        run_vec(64'h7FF8_0000_0000_0000, 2'b00, "R2 qnan");
        run_vec(64'hFFF8_0000_0000_1234, 2'b10, "R2 -qnan");
        run_vec(64'h8000_0000_0000_0000, 2'b11, "R3 -zero");
        run_vec(64'h4330_0000_0000_0000, 2'b00, "R3 2^52");
        run_vec(64'h000F_FFFF_FFFF_FFFF, 2'b01, "R3 denormal chop");
        run_vec(64'h4004_0000_0000_0000, 2'b00, "R4 2.5 tie even");
        run_vec(64'h400C_0000_0000_0000, 2'b00, "R4 3.5 tie even");
        run_vec(64'h4006_0000_0000_0000, 2'b00, "R4 2.75");
        run_vec(64'h4004_0000_0000_0000, 2'b01, "R5 2.5 chop");
        run_vec(64'h4004_0000_0000_0000, 2'b11, "R6 2.5 up");
        run_vec(64'h4004_0000_0000_0000, 2'b10, "R6 2.5 down");
        run_vec(64'hC004_0000_0000_0000, 2'b11, "R6 -2.5 up");
        run_vec(64'h3FD3_3333_3333_3333, 2'b10, "R6 0.3 down");
        run_vec(64'h3FF0_0000_0000_0000, 2'b00, "R7 exact 1.0");
        run_vec(64'h43D0_0000_0000_0000, 2'b00, "R8 2^62 no ovf");
        run_vec(64'h43E0_0000_0000_0000, 2'b00, "R8 2^63");
        run_vec(64'h43F0_0000_0000_0000, 2'b00, "R8 2^64 wrap");
        run_vec(64'hC3E0_0000_0000_0001, 2'b01, "R8 -2^63 ovf");
        run_vec(64'hBFF0_0000_0000_0000, 2'b00, "R9 -1.0");
        run_vec(64'hC05E_DD2F_1A9F_BE77, 2'b01, "R9 -123.456 chop");
        run_vec(64'h0000_0000_0000_0001, 2'b11, "R10 min denormal up");
        run_vec(64'h0000_0000_0000_0001, 2'b00, "R10 min denormal near");
        run_vec(64'h3C90_0000_0000_0001, 2'b11, "R10 tiny normal up");

        // R11: outputs hold without in_valid
        held = result;
        @(negedge clk);
        operand = 64'h4059_0000_0000_0000;
        @(negedge clk);
        checks++;
        if (result !== held || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 hold actual=%h/%b expected=%h/0", result, out_valid, held);
        end

        // Constrained random mix
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] op;
            logic [1:0]  rm;
            int          sel;
            op  = {$urandom, $urandom};
            rm  = 2'($urandom);
            sel = int'($urandom % 4);
            case (sel)
                1: op[62:52] = 11'(1000 + ($urandom % 90));
                2: op[62:52] = 11'd0;
                3: op[62:52] = 11'(1023 + ($urandom % 70));
                default: ;
            endcase
            case (rm)
                2'b00:   run_vec(op, rm, "R4 random");
                2'b01:   run_vec(op, rm, "R5 random");
                default: run_vec(op, rm, "R6 random");
            endcase
        end

        finish_run();
    end

endmodule